// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide, two-address register port of one eight-line interrupt controller. Software writes a short initialization sequence and then operational commands through it. The block holds the configuration that the rest of the controller uses: the vector base, the line mask, the priority rotation offset, and the mode flags. These flags are automatic end-of-interrupt, rotate on automatic end-of-interrupt, special mask and special nesting. It also owns the in-service register. That register is set by the acknowledge logic through `isr_set_i` and cleared by end-of-interrupt commands and by poll reads.

The priority resolver lives outside this block. The resolver presents its current winner on `win_valid_i`/`win_line_i` and its request register on `irr_i`. A poll read returns that winner and pulses `irr_clr_o` so that the request holder drops the line. The acknowledge path watches `init_active_o`, which stays high from the first initialization word until the sequence completes.

Top module: `pic_cmd_port`

## Requirements
- R1: A write at address 0 with data bit 4 set starts initialization. The next cycle has mask, in-service, rotation offset, vector base and every mode flag at 0, poll disarmed, and `init_active_o` high. Data bit 0 is latched as "final mode word follows" and bit 1 as "single controller".
- R2: The first address-1 write after initialization start loads the vector base with data AND 0xF8. The next step is the cascade word when not single. When single, it is the final mode word if that word is flagged, else normal operation.
- R3: An address-1 write in the cascade step has no effect on the outputs. It moves to the final mode word if flagged, else to normal. The final mode word sets special nesting from bit 4 and automatic end-of-interrupt from bit 1, then returns to normal and drops `init_active_o`.
- R4: In normal operation an address-1 write loads the mask register with the data byte.
- R5: An address-0 write with bit 4 clear and bit 3 set is a mode word. Bit 2 arms a poll. Bit 1 set copies bit 0 into read-select. Bit 6 set copies bit 5 into special mask.
- R6: An address-0 write with bits 4 and 3 clear is a command with code = bits 7..5. Codes 0 and 4 set rotate-on-automatic-EOI to bit 7. Code 2 changes nothing.
- R7: Code 1 clears the in-service bit of highest priority, where priority p belongs to line (p + offset) mod 8 and p = 0 is highest. Code 5 does the same and sets the offset to that line + 1 mod 8. With no in-service bit set, neither code changes anything.
- R8: Code 3 clears in-service bit (data AND 7). Code 7 clears that bit and sets the offset to (data + 1) mod 8. Code 6 only sets the offset to (data + 1) mod 8.
- R9: With no poll armed, a read at address 1 returns the mask. A read at address 0 returns the in-service register when read-select is 1, else `irr_i`.
- R10: With a poll armed, a read returns the winning line number and, in the same cycle, pulses the one-hot `irr_clr_o` bit of that line; its in-service bit clears on the next edge. With no winner the read returns 7 and `irr_clr_o` stays 0. Any read disarms the poll.
- R11: Reset leaves every register at 0 and the port in normal operation. In the same cycle, `isr_set_i` bits are ORed into the in-service register and a clear of the same bit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| addr_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| irr_i | input | 8 | Request register from the resolver |
| win_valid_i | input | 1 | Resolver has a winning line |
| win_line_i | input | 3 | Winning line number |
| isr_set_i | input | 8 | In-service set bits from acknowledge logic |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| irr_clr_o | output | 8 | One-hot request clear on a poll read |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| mask_o | output | 8 | Line mask |
| isr_o | output | 8 | In-service register |
| prio_off_o | output | 3 | Line that currently holds top priority |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-interrupt |
| spec_mask_o | output | 1 | Special mask mode |
| spec_nest_o | output | 1 | Special fully nested mode |
| init_active_o | output | 1 | Initialization sequence in progress |

## Verification
The hardest state to reach is a non-specific end-of-interrupt under a non-zero rotation offset with several in-service bits set. Only that combination shows whether the scan starts from the rotated top line rather than line 0. The stimulus first loads all in-service bits through the acknowledge input, moves the offset with a priority-set command, and then issues a rotating non-specific end-of-interrupt. The bench then sees the cleared line and the new offset together. Every initialization path is driven explicitly: cascade with and without the final word, and single with and without it. A long random phase follows, in which a behavioural model tracks every output each cycle.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  typedef enum logic [1:0] {
    STEP_RUN  = 2'd0,
    STEP_BASE = 2'd1,
    STEP_CASC = 2'd2,
    STEP_MODE = 2'd3
  } init_step_e;

  typedef enum logic [2:0] {
    OP_RAEOI_CLR  = 3'd0,
    OP_EOI_NS     = 3'd1,
    OP_NOP        = 3'd2,
    OP_EOI_SP     = 3'd3,
    OP_RAEOI_SET  = 3'd4,
    OP_EOI_NS_ROT = 3'd5,
    OP_SET_PRIO   = 3'd6,
    OP_EOI_SP_ROT = 3'd7
  } op_cmd_e;

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       four_i,
  input  logic       single_i,
  input  logic       wr1_i,
  output init_step_e step_o,
  output logic       ld_base_o,
  output logic       ld_mode_o,
  output logic       ld_mask_o
);

  init_step_e step_q;
  logic       four_q, single_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= STEP_RUN;
      four_q   <= 1'b0;
      single_q <= 1'b0;
    end else if (start_i) begin
      step_q   <= STEP_BASE;
      four_q   <= four_i;
      single_q <= single_i;
    end else if (wr1_i) begin
      unique case (step_q)
        STEP_BASE: step_q <= !single_q ? STEP_CASC : (four_q ? STEP_MODE : STEP_RUN);
        STEP_CASC: step_q <= four_q ? STEP_MODE : STEP_RUN;
        STEP_MODE: step_q <= STEP_RUN;
        default:   step_q <= STEP_RUN;
      endcase
    end
  end

  assign step_o    = step_q;
  assign ld_base_o = wr1_i && step_q == STEP_BASE;
  assign ld_mode_o = wr1_i && step_q == STEP_MODE;
  assign ld_mask_o = wr1_i && step_q == STEP_RUN;

  AST_START_TO_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> step_q == STEP_BASE); // R1
  AST_SINGLE_SKIPS_CASC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr1_i && !start_i && single_q && step_q == STEP_BASE) |=> step_q != STEP_CASC); // R2
  AST_MODE_ENDS_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr1_i && !start_i && step_q == STEP_MODE) |=> step_q == STEP_RUN); // R3

endmodule

// File: rtl/pic_isr_unit.sv
module pic_isr_unit
  import pic_cmd_pkg::*;
#(
  parameter int LINE_W = 3,
  localparam int NLINES = 1 << LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_all_i,
  input  logic [NLINES-1:0] set_i,
  input  logic              op_valid_i,
  input  op_cmd_e           op_i,
  input  logic [LINE_W-1:0] op_line_i,
  input  logic [NLINES-1:0] poll_clr_i,
  output logic [NLINES-1:0] isr_o,
  output logic [LINE_W-1:0] off_o
);

  logic [NLINES-1:0] isr_q, eoi_clr;
  logic [LINE_W-1:0] off_q, off_nxt, hp_line, idx;
  logic              hp_found, off_ld;

  // rotated scan: priority p maps to line (p + off); lowest p wins
  always_comb begin
    hp_found = 1'b0;
    hp_line  = '0;
    idx      = '0;
    for (int p = NLINES - 1; p >= 0; p--) begin
      idx = LINE_W'(p) + off_q;
      if (isr_q[idx]) begin
        hp_found = 1'b1;
        hp_line  = idx;
      end
    end
  end

  always_comb begin
    eoi_clr = '0;
    off_ld  = 1'b0;
    off_nxt = off_q;
    if (op_valid_i) begin
      unique case (op_i)
        OP_EOI_NS: if (hp_found) eoi_clr[hp_line] = 1'b1;
        OP_EOI_NS_ROT: if (hp_found) begin
          eoi_clr[hp_line] = 1'b1;
          off_ld  = 1'b1;
          off_nxt = hp_line + 1'b1;
        end
        OP_EOI_SP: eoi_clr[op_line_i] = 1'b1;
        OP_SET_PRIO: begin
          off_ld  = 1'b1;
          off_nxt = op_line_i + 1'b1;
        end
        OP_EOI_SP_ROT: begin
          eoi_clr[op_line_i] = 1'b1;
          off_ld  = 1'b1;
          off_nxt = op_line_i + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      off_q <= '0;
    end else if (clear_all_i) begin
      isr_q <= '0;
      off_q <= '0;
    end else begin
      isr_q <= (isr_q | set_i) & ~eoi_clr & ~poll_clr_i;
      if (off_ld) off_q <= off_nxt;
    end
  end

  assign isr_o = isr_q;
  assign off_o = off_q;

  AST_NS_EOI_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_EOI_NS && set_i == '0 && poll_clr_i == '0 && isr_q != '0)
    |=> $countones(isr_q) == $countones($past(isr_q)) - 1); // R7
  AST_SP_EOI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_EOI_SP && set_i == '0) |=> !isr_q[$past(op_line_i)]); // R8
  AST_SET_PRIO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_SET_PRIO && !clear_all_i)
    |=> off_q == LINE_W'($past(op_line_i) + 1'b1)); // R8

endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINE_W = 3,
  localparam int NLINES = 1 << LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NLINES-1:0] irr_i,
  input  logic              win_valid_i,
  input  logic [LINE_W-1:0] win_line_i,
  input  logic [NLINES-1:0] isr_set_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NLINES-1:0] irr_clr_o,
  output logic [DATA_W-1:0] vec_base_o,
  output logic [NLINES-1:0] mask_o,
  output logic [NLINES-1:0] isr_o,
  output logic [LINE_W-1:0] prio_off_o,
  output logic              auto_eoi_o,
  output logic              rot_aeoi_o,
  output logic              spec_mask_o,
  output logic              spec_nest_o,
  output logic              init_active_o
);

  localparam logic [DATA_W-1:0] BASE_KEEP = ~DATA_W'((1 << LINE_W) - 1);

  logic       wr0, wr1, start, mode_wr, op_wr, poll_hit;
  logic       ld_base, ld_mode, ld_mask;
  init_step_e step;
  op_cmd_e    op;

  logic [NLINES-1:0] mask_q, poll_clr;
  logic [DATA_W-1:0] base_q;
  logic poll_q, rsel_q, smm_q, aeoi_q, raeoi_q, sfnm_q;

  assign wr0     = wr_i && !addr_i;
  assign wr1     = wr_i && addr_i;
  assign start   = wr0 && wdata_i[4];
  assign mode_wr = wr0 && !wdata_i[4] && wdata_i[3];
  assign op_wr   = wr0 && !wdata_i[4] && !wdata_i[3];
  assign op      = op_cmd_e'(wdata_i[7:5]);

  pic_init_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .four_i    (wdata_i[0]),
    .single_i  (wdata_i[1]),
    .wr1_i     (wr1),
    .step_o    (step),
    .ld_base_o (ld_base),
    .ld_mode_o (ld_mode),
    .ld_mask_o (ld_mask)
  );

  assign poll_hit = rd_i && poll_q && win_valid_i;

  for (genvar i = 0; i < NLINES; i++) begin : g_pclr
    assign poll_clr[i] = poll_hit && win_line_i == LINE_W'(i);
  end

  pic_isr_unit #(.LINE_W(LINE_W)) u_isr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_all_i (start),
    .set_i       (isr_set_i),
    .op_valid_i  (op_wr),
    .op_i        (op),
    .op_line_i   (wdata_i[LINE_W-1:0]),
    .poll_clr_i  (poll_clr),
    .isr_o       (isr_o),
    .off_o       (prio_off_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      base_q  <= '0;
      poll_q  <= 1'b0;
      rsel_q  <= 1'b0;
      smm_q   <= 1'b0;
      aeoi_q  <= 1'b0;
      raeoi_q <= 1'b0;
      sfnm_q  <= 1'b0;
    end else if (start) begin
      mask_q  <= '0;
      base_q  <= '0;
      poll_q  <= 1'b0;
      rsel_q  <= 1'b0;
      smm_q   <= 1'b0;
      aeoi_q  <= 1'b0;
      raeoi_q <= 1'b0;
      sfnm_q  <= 1'b0;
    end else begin
      if (ld_mask) mask_q <= wdata_i[NLINES-1:0];
      if (ld_base) base_q <= wdata_i & BASE_KEEP;
      if (ld_mode) begin
        sfnm_q <= wdata_i[4];
        aeoi_q <= wdata_i[1];
      end
      if (mode_wr && wdata_i[2]) poll_q <= 1'b1;
      else if (rd_i)             poll_q <= 1'b0;
      if (mode_wr && wdata_i[1]) rsel_q <= wdata_i[0];
      if (mode_wr && wdata_i[6]) smm_q  <= wdata_i[5];
      if (op_wr && (op == OP_RAEOI_CLR || op == OP_RAEOI_SET)) raeoi_q <= wdata_i[7];
    end
  end

  always_comb begin
    if (poll_q)      rdata_o = win_valid_i ? DATA_W'(win_line_i) : DATA_W'(NLINES - 1);
    else if (addr_i) rdata_o = DATA_W'(mask_q);
    else if (rsel_q) rdata_o = DATA_W'(isr_o);
    else             rdata_o = DATA_W'(irr_i);
  end

  assign irr_clr_o     = poll_clr;
  assign vec_base_o    = base_q;
  assign mask_o        = mask_q;
  assign auto_eoi_o    = aeoi_q;
  assign rot_aeoi_o    = raeoi_q;
  assign spec_mask_o   = smm_q;
  assign spec_nest_o   = sfnm_q;
  assign init_active_o = step != STEP_RUN;

  AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (mask_o == '0 && isr_o == '0 && prio_off_o == '0 && vec_base_o == '0)); // R1
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr1 && step == STEP_RUN) |=> mask_o == $past(wdata_i[NLINES-1:0])); // R4
  AST_POLL_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && poll_q && !(mode_wr && wdata_i[2])) |=> !poll_q); // R10
  AST_POLL_ISR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_hit && isr_set_i == '0) |=> !isr_o[$past(win_line_i)]); // R10
  AST_BASE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i) |=> $stable(vec_base_o)); // R2

endmodule

// File: tb/pic_cmd_port_tb.sv
`timescale 1ns/1ps
module pic_cmd_port_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 0, rd = 0, addr = 0, winv = 0;
  logic [7:0] wd = 0, irr = 0, iset = 0;
  logic [2:0] winl = 0;

  logic [7:0] rdata, irr_clr, vbase, mask, isr;
  logic [2:0] poff;
  logic       aeoi, raeoi, smm, sfnm, iact;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pic_cmd_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wd), .irr_i(irr), .win_valid_i(winv), .win_line_i(winl),
    .isr_set_i(iset), .rdata_o(rdata), .irr_clr_o(irr_clr),
    .vec_base_o(vbase), .mask_o(mask), .isr_o(isr), .prio_off_o(poff),
    .auto_eoi_o(aeoi), .rot_aeoi_o(raeoi), .spec_mask_o(smm),
    .spec_nest_o(sfnm), .init_active_o(iact)
  );

  // reference model state
  logic [7:0] m_mask = 0, m_isr = 0, m_base = 0;
  int m_off = 0, m_step = 0;
  bit m_poll = 0, m_rsel = 0, m_smm = 0, m_aeoi = 0, m_raeoi = 0, m_sfnm = 0;
  bit m_four = 0, m_single = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_isr = 0; m_base = 0; m_off = 0; m_step = 0;
      m_poll = 0; m_rsel = 0; m_smm = 0; m_aeoi = 0; m_raeoi = 0; m_sfnm = 0;
      m_four = 0; m_single = 0;
    end else begin
      logic [7:0] clr;
      bit init_now;
      clr = 0;
      init_now = 0;
      if (rd && m_poll) begin
        if (winv) clr[winl] = 1'b1;
        m_poll = 0;
      end
      if (wr && !addr) begin
        if (wd[4]) begin
          init_now = 1;
          m_mask = 0; m_base = 0; m_off = 0; m_poll = 0; m_rsel = 0;
          m_smm = 0; m_aeoi = 0; m_raeoi = 0; m_sfnm = 0;
          m_step = 1; m_four = wd[0]; m_single = wd[1];
        end else if (wd[3]) begin
          if (wd[2]) m_poll = 1;
          if (wd[1]) m_rsel = wd[0];
          if (wd[6]) m_smm = wd[5];
        end else begin
          int code, top;
          code = int'(wd[7:5]);
          top = -1;
          for (int p = 7; p >= 0; p--) if (m_isr[(p + m_off) % 8]) top = (p + m_off) % 8;
          case (code)
            0, 4: m_raeoi = wd[7];
            1: if (top >= 0) clr[top] = 1'b1;
            5: if (top >= 0) begin clr[top] = 1'b1; m_off = (top + 1) % 8; end
            3: clr[wd[2:0]] = 1'b1;
            6: m_off = (int'(wd[2:0]) + 1) % 8;
            7: begin clr[wd[2:0]] = 1'b1; m_off = (int'(wd[2:0]) + 1) % 8; end
            default: ;
          endcase
        end
      end
      if (wr && addr) begin
        case (m_step)
          0: m_mask = wd;
          1: begin m_base = wd & 8'hF8; m_step = !m_single ? 2 : (m_four ? 3 : 0); end
          2: m_step = m_four ? 3 : 0;
          default: begin m_sfnm = wd[4]; m_aeoi = wd[1]; m_step = 0; end
        endcase
      end
      m_isr = init_now ? 8'h00 : ((m_isr | iset) & ~clr);
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] exp_rd, exp_clr;
    exp_clr = 0;
    if (m_poll) begin
      exp_rd = winv ? {5'd0, winl} : 8'd7;
      if (rd && winv) exp_clr[winl] = 1'b1;
    end else if (addr) exp_rd = m_mask;
    else if (m_rsel) exp_rd = m_isr;
    else exp_rd = irr;
    if (rd) begin
      if (m_poll) chk("R10 poll data", int'(rdata), int'(exp_rd));
      else        chk("R9 read data", int'(rdata), int'(exp_rd));
    end
    chk("R10 irr_clr", int'(irr_clr), int'(exp_clr));
    chk("R1 init_active", int'(iact), int'(m_step != 0));
    chk("R2 vec_base", int'(vbase), int'(m_base));
    chk("R3 auto_eoi", int'(aeoi), int'(m_aeoi));
    chk("R3 spec_nest", int'(sfnm), int'(m_sfnm));
    chk("R4 mask", int'(mask), int'(m_mask));
    chk("R5 spec_mask", int'(smm), int'(m_smm));
    chk("R6 rot_aeoi", int'(raeoi), int'(m_raeoi));
    chk("R7 isr", int'(isr), int'(m_isr));
    chk("R8 prio_off", int'(poff), m_off);
  endtask

  task automatic cyc(bit w, bit r, bit a, logic [7:0] d,
                     bit wv = 0, logic [2:0] wl = 0, logic [7:0] s = 0, logic [7:0] q = 0);
    @(negedge clk);
    wr = w; rd = r; addr = a; wd = d; winv = wv; winl = wl; iset = s; irr = q;
    #1;
    compare_all();
  endtask

  task automatic wr0(logic [7:0] d); cyc(1, 0, 0, d); endtask
  task automatic wr1(logic [7:0] d); cyc(1, 0, 1, d); endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset values
    chk("R11 reset mask", int'(mask), 0);
    chk("R11 reset isr", int'(isr), 0);
    chk("R11 reset base", int'(vbase), 0);
    chk("R11 reset flags", int'({aeoi, raeoi, smm, sfnm, iact}), 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);

    // cascade, fourth word: base, cascade, mode
    wr0(8'h11); wr1(8'h47); wr1(8'h04); wr1(8'h12);
    wr1(8'hA5);                       // R4 mask
    cyc(0, 1, 1, 0);                  // R9 mask read
    // single with fourth word
    wr0(8'h13); wr1(8'h6F); wr1(8'h10); wr1(8'h3C);
    // single without fourth word
    wr0(8'h12); wr1(8'hFF); wr1(8'h81);
    // cascade without fourth word
    wr0(8'h10); wr1(8'h20); wr1(8'h99); wr1(8'h0F);

    // R7/R8 end-of-interrupt handling under rotation
    cyc(0, 0, 0, 0, 0, 0, 8'hFF);
    wr0(8'h20);                       // nonspecific: clears line 0
    wr0(8'hC5);                       // offset 6
    wr0(8'hA0);                       // rotating nonspecific: line 6, offset 7
    wr0(8'h63);                       // specific line 3
    wr0(8'hE2);                       // specific rotating line 2, offset 3
    wr0(8'h40);                       // no-op
    wr0(8'h20);                       // clears line 4 under offset 3
    wr0(8'h80); wr0(8'h00); wr0(8'h80);   // R6
    cyc(0, 0, 0, 0, 0, 0, 8'h00);
    wr0(8'hE0); wr0(8'hE1);
    wr0(8'h20); wr0(8'h20); wr0(8'h20); wr0(8'h20); wr0(8'hA0); // empties isr, then no-op

    // R5/R9 read select
    cyc(0, 0, 0, 0, 0, 0, 8'h5A);
    wr0(8'h0B); cyc(0, 1, 0, 0, 0, 0, 0, 8'hC3);
    wr0(8'h0A); cyc(0, 1, 0, 0, 0, 0, 0, 8'hC3);
    wr0(8'h09); cyc(0, 1, 0, 0, 0, 0, 0, 8'h3C);  // bit1 clear: select unchanged
    // R10 poll
    wr0(8'h6C); cyc(0, 1, 0, 0, 1, 3'd4, 0, 8'h10);
    cyc(0, 1, 0, 0, 1, 3'd4, 0, 8'h10);            // poll gone
    wr0(8'h0C); cyc(0, 1, 1, 0, 0, 3'd0);          // none: 7
    wr0(8'h48); wr0(8'h60);

    for (int i = 0; i < 600; i++) begin
      bit w, r, a, wv;
      logic [7:0] d, s;
      w = 1'($urandom % 2);
      r = !w && ($urandom % 3 == 0);
      a = 1'($urandom % 2);
      d = 8'($urandom);
      if (d[4] && ($urandom % 5 != 0)) d[4] = 1'b0;
      s = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      wv = 1'($urandom % 2);
      cyc(w, r, a, d, wv, 3'($urandom), s, 8'($urandom));
    end
    cyc(0, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule